// File: doc/BRIEF.md
# Processor Status Flag Register

An eight-bit status register for a small processor core. It gathers the ALU condition flags (zero, half-carry, carry), a two-bit program page selector that the program counter logic reads whenever a jump or call loads a new address, a general-purpose spare bit, and two flags that record why the core last woke or reset: a time-out flag and a power-down flag.

The CPU data path can write the register as a whole. That write changes only the spare bit, the page bits and the three ALU flags. The time-out and power-down flags are driven only by event strobes from the sleep instruction, the watchdog-clear instruction, a watchdog time-out, and power-on reset. The ALU drives each of its flags through a separate update strobe. The zero flag comes from a comparison of the ALU result with zero inside this block.

Top module: `status_flag_reg`

## Requirements
- R1: While the active-low power-on reset `rst_n` is low, and on the first cycle after it is released, `stat_q` is 8'h18. That is bit 4 (time-out) = 1, bit 3 (power-down) = 1 and every other bit = 0, so `page_sel` = 0.
- R2: A cycle with `cpu_wr` high loads bits 7, 6, 5, 2, 1 and 0 of `stat_q` from the matching bits of `cpu_wdata` on the next edge. Bits 4 and 3 keep their values.
- R3: `page_sel[1:0]` always equals `stat_q[6:5]`.
- R4: Time-out flag (bit 4): `ev_wdt_tmo` clears it. Otherwise `ev_sleep` or `ev_wdt_clr` sets it. A time-out in the same cycle as either set strobe leaves it 0.
- R5: Power-down flag (bit 3): `ev_sleep` clears it. Otherwise `ev_wdt_clr` sets it. Sleep wins when both arrive in the same cycle. A watchdog time-out alone leaves it unchanged.
- R6: When `alu_z_we` is high, bit 2 becomes 1 if `alu_result` is all zeros and 0 otherwise.
- R7: When `alu_hc_we` is high, bit 1 takes `alu_hc`. When `alu_c_we` is high, bit 0 takes `alu_c`.
- R8: If an ALU strobe and `cpu_wr` hit the same flag bit in one cycle, the ALU value is stored. Bits that are not strobed still take the CPU write.
- R9: If an event strobe and `cpu_wr` arrive together, bits 4 and 3 follow only the event rules of R4 and R5.
- R10: With no write, no ALU strobe and no event strobe, `stat_q` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| cpu_wr | input | 1 | CPU write enable |
| cpu_wdata | input | 8 | CPU write data |
| alu_z_we | input | 1 | Zero flag update strobe |
| alu_result | input | DATA_W | ALU result used for the zero test |
| alu_hc_we | input | 1 | Half-carry update strobe |
| alu_hc | input | 1 | Half-carry value |
| alu_c_we | input | 1 | Carry update strobe |
| alu_c | input | 1 | Carry value |
| ev_sleep | input | 1 | Sleep instruction executed |
| ev_wdt_clr | input | 1 | Watchdog-clear instruction executed |
| ev_wdt_tmo | input | 1 | Watchdog time-out |
| stat_q | output | 8 | Register value |
| page_sel | output | 2 | Program page select to PC logic |

## Verification
The bench targets collisions: CPU writes that carry ones and zeros in the time-out and power-down positions, where a design that let the write through would corrupt the wake-cause record. It drives sleep together with watchdog-clear, and time-out together with sleep, so a wrong priority appears as an inverted flag. ALU strobes that coincide with a CPU write on only some flag bits expose a design that lets the write win, or one that blocks the whole write. Results that are zero except in the top bit, and the all-zero result, catch a zero test that looks at too few bits.

// File: rtl/status_flag_reg.sv
module status_flag_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [7:0]        cpu_wdata,
  input  logic              alu_z_we,
  input  logic [DATA_W-1:0] alu_result,
  input  logic              alu_hc_we,
  input  logic              alu_hc,
  input  logic              alu_c_we,
  input  logic              alu_c,
  input  logic              ev_sleep,
  input  logic              ev_wdt_clr,
  input  logic              ev_wdt_tmo,
  output logic [7:0]        stat_q,
  output logic [1:0]        page_sel
);
  localparam logic [7:0] RST_VAL = 8'h18;

  logic [7:0] q;
  logic [7:0] nxt;
  logic       res_zero;

  assign res_zero = (alu_result == '0);

  always_comb begin
    nxt = q;
    if (cpu_wr) begin
      nxt[7:5] = cpu_wdata[7:5];
      nxt[2:0] = cpu_wdata[2:0];
    end
    if (alu_z_we)  nxt[2] = res_zero;
    if (alu_hc_we) nxt[1] = alu_hc;
    if (alu_c_we)  nxt[0] = alu_c;
    if (ev_wdt_tmo)                nxt[4] = 1'b0;
    else if (ev_sleep || ev_wdt_clr) nxt[4] = 1'b1;
    if (ev_sleep)        nxt[3] = 1'b0;
    else if (ev_wdt_clr) nxt[3] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) q <= RST_VAL;
    else        q <= nxt;

  assign stat_q   = q;
  assign page_sel = q[6:5];

  logic quiet;
  assign quiet = !cpu_wr && !alu_z_we && !alu_hc_we && !alu_c_we
                 && !ev_sleep && !ev_wdt_clr && !ev_wdt_tmo;

  assert_rst_val_R1: assert property (@(posedge clk) !rst_n |=> stat_q == 8'h18);

  assert_wr_keeps_tp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !ev_sleep && !ev_wdt_clr && !ev_wdt_tmo) |=> $stable(stat_q[4:3]));

  assert_tmo_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wdt_tmo |=> !stat_q[4]);

  assert_t_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_wdt_tmo && (ev_sleep || ev_wdt_clr)) |=> stat_q[4]);

  assert_sleep_clears_p_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sleep |=> !stat_q[3]);

  assert_clr_sets_p_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wdt_clr && !ev_sleep) |=> stat_q[3]);

  assert_zero_test_R6: assert property (@(posedge clk) disable iff (!rst_n)
    alu_z_we |=> stat_q[2] == ($past(alu_result) == '0));

  assert_alu_over_cpu_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_c_we && cpu_wr) |=> stat_q[0] == $past(alu_c));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> $stable(stat_q));
endmodule

// File: tb/test_status_flag_reg.sv
module test_status_flag_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_wr = 0, alu_z_we = 0, alu_hc_we = 0, alu_hc = 0, alu_c_we = 0, alu_c = 0;
  logic ev_sleep = 0, ev_wdt_clr = 0, ev_wdt_tmo = 0;
  logic [7:0] cpu_wdata = '0, alu_result = '0;
  logic [7:0] stat_q;
  logic [1:0] page_sel;

  always #5 clk = ~clk;

  status_flag_reg #(.DATA_W(8)) i_status_flag_reg (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .alu_z_we(alu_z_we), .alu_result(alu_result), .alu_hc_we(alu_hc_we), .alu_hc(alu_hc),
    .alu_c_we(alu_c_we), .alu_c(alu_c), .ev_sleep(ev_sleep), .ev_wdt_clr(ev_wdt_clr),
    .ev_wdt_tmo(ev_wdt_tmo), .stat_q(stat_q), .page_sel(page_sel));

  typedef struct { logic [7:0] val; string tag; } item_t;
  item_t sb[$];
  logic [7:0] model;
  int vectors = 0, miscompares = 0;
  bit done = 0;

  function automatic void compare(logic [7:0] exp, string tag);
    vectors++;
    if (stat_q !== exp) begin
      miscompares++;
      $display("FAIL %s stat_q act=%h exp=%h", tag, stat_q, exp);
    end
    if (page_sel !== exp[6:5]) begin
      miscompares++;
      $display("FAIL R3 page_sel act=%h exp=%h (%s)", page_sel, exp[6:5], tag);
    end
  endfunction

  task automatic apply(input bit wr, input logic [7:0] d, input bit zwe, input logic [7:0] res,
                       input bit hwe, input bit h, input bit cwe, input bit c,
                       input bit sl, input bit cl, input bit to, input string tag);
    item_t it;
    @(negedge clk);
    cpu_wr = wr; cpu_wdata = d; alu_z_we = zwe; alu_result = res;
    alu_hc_we = hwe; alu_hc = h; alu_c_we = cwe; alu_c = c;
    ev_sleep = sl; ev_wdt_clr = cl; ev_wdt_tmo = to;
    if (wr) begin model[7:5] = d[7:5]; model[2:0] = d[2:0]; end
    if (zwe) model[2] = (res == 8'h00);
    if (hwe) model[1] = h;
    if (cwe) model[0] = c;
    if (to) model[4] = 1'b0; else if (sl || cl) model[4] = 1'b1;
    if (sl) model[3] = 1'b0; else if (cl) model[3] = 1'b1;
    it.val = model; it.tag = tag;
    sb.push_back(it);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk); #1;
      if (sb.size() != 0) begin
        item_t it;
        it = sb.pop_front();
        compare(it.val, it.tag);
      end
    end
  end

  initial begin : watchdog
    #200000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin : driver
    #12 compare(8'h18, "R1 in reset");
    model = 8'h18;
    @(negedge clk); rst_n = 1'b1;
    #2 compare(8'h18, "R1 after release");
    apply(0, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10 idle");
    apply(1, 8'hE7, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 write ones, T/P kept");
    apply(1, 8'h18, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 write zeros, T/P kept");
    apply(1, 8'h40, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R3 page 2");
    apply(1, 8'h20, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R3 page 1");
    apply(0, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R4 timeout clears T");
    apply(0, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10 hold after timeout");
    apply(0, 8'h00, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R4 R5 sleep sets T clears P");
    apply(0, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R5 timeout leaves P");
    apply(0, 8'h00, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R4 R5 wdt clear sets T and P");
    apply(0, 8'h00, 0, 0, 0, 0, 0, 0, 1, 1, 0, "R5 sleep beats clear");
    apply(0, 8'h00, 0, 0, 0, 0, 0, 0, 1, 0, 1, "R4 timeout beats sleep");
    apply(1, 8'hFF, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R9 clear with write");
    apply(1, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R9 timeout with write");
    apply(1, 8'h18, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R9 sleep with write");
    apply(0, 8'h00, 1, 8'h00, 0, 0, 0, 0, 0, 0, 0, "R6 zero result");
    apply(0, 8'h00, 1, 8'h80, 0, 0, 0, 0, 0, 0, 0, "R6 top bit only");
    apply(0, 8'h00, 1, 8'h01, 0, 0, 0, 0, 0, 0, 0, "R6 low bit only");
    apply(0, 8'h00, 0, 0, 1, 1, 1, 1, 0, 0, 0, "R7 set HC and C");
    apply(0, 8'h00, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R7 HC only");
    apply(1, 8'hA7, 1, 8'h05, 0, 0, 1, 0, 0, 0, 0, "R8 ALU Z and C beat write");
    apply(1, 8'h00, 0, 0, 1, 1, 0, 0, 0, 0, 0, "R8 ALU HC beats write");
    apply(1, 8'h67, 1, 8'h00, 1, 0, 1, 0, 1, 0, 1, "R8 R9 all at once");
    apply(0, 8'hFF, 0, 8'h00, 0, 1, 0, 1, 0, 0, 0, "R10 data without strobes");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule